// File: doc/BRIEF.md
# Device Operating Mode Controller

This block tracks which operating mode the chip is in and moves it between modes. Software asks for a new mode by writing a 4-bit mode code. Hardware fault sources can force the chip into the fail-safe mode. A status output stays high while a move is under way. The move finishes when the clock/power sequencer returns a done pulse, and the outputs keep the old mode's settings until that pulse arrives.

One input carries a configuration word for every mode. The block picks the word that belongs to the current mode and drives from it the clock-source select, the main regulator enable, the power-domain enables and the pad controls. A few forced rules are laid on top of the chosen word:

- Test mode always keeps the regulator and the two lowest power domains on.
- The fail-safe mode can float the output pads.
- A stopped clock in test mode can only be left through reset.

Top module: `opmode_ctrl`

## Requirements
- R1: While `rst_n` is low, `cur_mode` is RESET (0), `in_trans` is 1 and `ill_flag` is 0. A pending move to DRUN is already set up, so the first `seq_done` after reset lands the block in DRUN.
- R2: Mode codes are RESET=0, TEST=1, SAFE=2, DRUN=3 and RUN0..RUN3=4..7. An accepted write sets `in_trans` on the next edge. `cur_mode` only changes on an edge where `seq_done` is high. At that edge it takes the target value and `in_trans` clears.
- R3: Each configuration word is 6+NPD bits wide, and word k sits at `cfg_all[k*(6+NPD) +: 6+NPD]`. The fields are:
  - bits [3:0]: clock select
  - bit 4: regulator enable
  - bits [5 +: NPD]: power-domain enables
  - bit 5+NPD: pad disable

  The outputs always reflect the word of `cur_mode`.
- R4: The sticky `ill_flag` is set, and the write has no other effect, in any of these cases:
  - a code above 7;
  - a request for the current mode;
  - a write while `in_trans` is high, other than the redirect of R7.

  Only reset clears the flag.
- R5: TEST is accepted only when the current mode is DRUN. From any other mode it is illegal under R4.
- R6: From SAFE, only DRUN or RESET are accepted. Every other code is illegal.
- R7: While a move into SAFE is pending, a write of the current (parent) mode code redirects the move. The mode reached at the next `seq_done` is the parent mode, and `ill_flag` is not set.
- R8: While any `safe_evt` bit is high:
  - the target is forced to SAFE, pre-empting any pending move;
  - once in SAFE, the block stays there with `in_trans` low;
  - writes are ignored and leave `ill_flag` unchanged.
- R9: In TEST, `mvreg_en` is 1 and `pd_en[1:0]` is 2'b11, whatever the word holds. The other bits follow the word.
- R10: `pad_hiz` is 1 exactly when the mode is SAFE and the SAFE word's pad-disable bit is set. `pad_drv_en` is always the inverse of `pad_hiz`.
- R11: When the mode is TEST and the TEST word's clock select is 4'hF, `clk_stopped` is 1. Writes, fault events and `seq_done` then have no effect until reset.
- R12: An accepted RESET request lands in RESET at `seq_done` with `in_trans` still high. The next `seq_done` lands in DRUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode-control write strobe |
| wr_mode | input | 4 | Requested mode code |
| safe_evt | input | NSAFE | Hardware fault sources forcing SAFE |
| seq_done | input | 1 | Sequencer reports the move settled |
| cfg_all | input | 8*(6+NPD) | Per-mode configuration words |
| cur_mode | output | 4 | Current mode code |
| in_trans | output | 1 | Move in progress |
| ill_flag | output | 1 | Sticky illegal-request flag |
| sysclk_sel | output | 4 | Clock-source select |
| mvreg_en | output | 1 | Main regulator enable |
| pd_en | output | NPD | Power-domain enables |
| pad_hiz | output | 1 | Output pads forced to high impedance |
| pad_drv_en | output | 1 | Pad power-sequence driver enable |
| clk_stopped | output | 1 | System clock stopped in TEST |

## Verification
The hardest states to reach from the ports are the redirect window and the frozen test mode. The redirect needs a SAFE request that is still pending, followed by a write of the parent code before any `seq_done`. The frozen mode needs a TEST word with clock select 4'hF together with a legal path through DRUN. Random stimulus rarely lines these up. Directed sequences therefore build both on purpose and try every exit from the frozen state. A long seeded random run then mixes fault bursts, illegal codes and done pulses, and compares each cycle against a reference model.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
  localparam int MODE_W    = 4;
  localparam int NUM_MODES = 8;

  localparam logic [MODE_W-1:0] MD_RESET = 4'd0;
  localparam logic [MODE_W-1:0] MD_TEST  = 4'd1;
  localparam logic [MODE_W-1:0] MD_SAFE  = 4'd2;
  localparam logic [MODE_W-1:0] MD_DRUN  = 4'd3;
  localparam logic [MODE_W-1:0] MD_RUN0  = 4'd4;

  localparam logic [3:0] CLK_STOP_CODE = 4'hF;
endpackage

// File: rtl/opmode_req_check.sv
module opmode_req_check
  import opmode_pkg::*;
(
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] req_mode,
  output logic              legal
);
  always_comb begin
    legal = 1'b1;
    if (req_mode >= MODE_W'(NUM_MODES)) begin
      legal = 1'b0;
    end else if (req_mode == cur_mode) begin
      legal = 1'b0;
    end else if (cur_mode == MD_SAFE && !(req_mode == MD_DRUN || req_mode == MD_RESET)) begin
      legal = 1'b0;
    end else if (req_mode == MD_TEST && cur_mode != MD_DRUN) begin
      legal = 1'b0;
    end
  end
endmodule

// File: rtl/opmode_fsm.sv
module opmode_fsm
  import opmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              safe_any,
  input  logic              seq_done,
  input  logic              legal,
  input  logic              frozen,
  output logic [MODE_W-1:0] cur_q,
  output logic              tr_q,
  output logic              ill_q
);
  logic [MODE_W-1:0] tgt_q, cur_d, tgt_d;
  logic              tr_d, ill_d, redirect, upd_en;

  assign upd_en   = !frozen;
  assign redirect = wr_en && tr_q && (tgt_q == MD_SAFE) && (wr_mode == cur_q);

  always_comb begin
    cur_d = cur_q;
    tgt_d = tgt_q;
    tr_d  = tr_q;
    ill_d = ill_q;
    if (safe_any) begin
      if (cur_q == MD_SAFE) begin
        tgt_d = MD_SAFE;
        tr_d  = 1'b0;
      end else if (tr_q && tgt_q == MD_SAFE && seq_done) begin
        cur_d = MD_SAFE;
        tr_d  = 1'b0;
      end else begin
        tgt_d = MD_SAFE;
        tr_d  = 1'b1;
      end
    end else if (redirect) begin
      tgt_d = cur_q;
    end else if (tr_q) begin
      if (wr_en) ill_d = 1'b1;
      if (seq_done) begin
        if (tgt_q == MD_RESET) begin
          cur_d = MD_RESET;
          tgt_d = MD_DRUN;
          tr_d  = 1'b1;
        end else begin
          cur_d = tgt_q;
          tr_d  = 1'b0;
        end
      end
    end else if (wr_en) begin
      if (legal) begin
        tgt_d = wr_mode;
        tr_d  = 1'b1;
      end else begin
        ill_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= MD_RESET;
      tgt_q <= MD_DRUN;
      tr_q  <= 1'b1;
      ill_q <= 1'b0;
    end else if (upd_en) begin
      cur_q <= cur_d;
      tgt_q <= tgt_d;
      tr_q  <= tr_d;
      ill_q <= ill_d;
    end
  end
endmodule

// File: rtl/opmode_cfg_sel.sv
module opmode_cfg_sel
  import opmode_pkg::*;
#(
  parameter int NPD = 4
) (
  input  logic [MODE_W-1:0]             cur_mode,
  input  logic [NUM_MODES*(6+NPD)-1:0]  cfg_all,
  output logic [3:0]                    sysclk_sel,
  output logic                          mvreg_en,
  output logic [NPD-1:0]                pd_en,
  output logic                          pad_hiz,
  output logic                          pad_drv_en,
  output logic                          clk_stopped
);
  localparam int CFG_W   = 6 + NPD;
  localparam int MV_BIT  = 4;
  localparam int PD_LSB  = 5;
  localparam int PAD_BIT = PD_LSB + NPD;
  localparam int IDX_W   = $clog2(NUM_MODES);

  logic [CFG_W-1:0] words [NUM_MODES];
  logic [CFG_W-1:0] sel;
  logic             is_test, is_safe;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_unpack
    assign words[g] = cfg_all[g*CFG_W +: CFG_W];
  end

  assign sel     = (cur_mode < MODE_W'(NUM_MODES)) ? words[cur_mode[IDX_W-1:0]] : '0;
  assign is_test = (cur_mode == MD_TEST);
  assign is_safe = (cur_mode == MD_SAFE);

  assign sysclk_sel  = sel[3:0];
  assign mvreg_en    = sel[MV_BIT] | is_test;
  assign pd_en       = sel[PD_LSB +: NPD] | (is_test ? NPD'(3) : '0);
  assign pad_hiz     = is_safe & sel[PAD_BIT];
  assign pad_drv_en  = !pad_hiz;
  assign clk_stopped = is_test && (sel[3:0] == CLK_STOP_CODE);
endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
  import opmode_pkg::*;
#(
  parameter int NPD   = 4,
  parameter int NSAFE = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [3:0]                    wr_mode,
  input  logic [NSAFE-1:0]              safe_evt,
  input  logic                          seq_done,
  input  logic [NUM_MODES*(6+NPD)-1:0]  cfg_all,
  output logic [3:0]                    cur_mode,
  output logic                          in_trans,
  output logic                          ill_flag,
  output logic [3:0]                    sysclk_sel,
  output logic                          mvreg_en,
  output logic [NPD-1:0]                pd_en,
  output logic                          pad_hiz,
  output logic                          pad_drv_en,
  output logic                          clk_stopped
);
  logic safe_any, legal;

  assign safe_any = |safe_evt;

  opmode_req_check u_chk_req (
    .cur_mode (cur_mode),
    .req_mode (wr_mode),
    .legal    (legal)
  );

  opmode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_mode  (wr_mode),
    .safe_any (safe_any),
    .seq_done (seq_done),
    .legal    (legal),
    .frozen   (clk_stopped),
    .cur_q    (cur_mode),
    .tr_q     (in_trans),
    .ill_q    (ill_flag)
  );

  opmode_cfg_sel #(.NPD(NPD)) u_cfg (
    .cur_mode    (cur_mode),
    .cfg_all     (cfg_all),
    .sysclk_sel  (sysclk_sel),
    .mvreg_en    (mvreg_en),
    .pd_en       (pd_en),
    .pad_hiz     (pad_hiz),
    .pad_drv_en  (pad_drv_en),
    .clk_stopped (clk_stopped)
  );
endmodule

// File: rtl/opmode_ctrl_chk.sv
module opmode_ctrl_chk
  import opmode_pkg::*;
#(
  parameter int NPD   = 4,
  parameter int NSAFE = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSAFE-1:0] safe_evt,
  input logic             seq_done,
  input logic [3:0]       cur_mode,
  input logic             in_trans,
  input logic             ill_flag,
  input logic             mvreg_en,
  input logic [NPD-1:0]   pd_en,
  input logic             pad_hiz,
  input logic             pad_drv_en,
  input logic             clk_stopped
);
  p_mode_moves_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done |=> $stable(cur_mode));

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ill_flag |=> ill_flag);

  p_safe_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MD_SAFE) |=> (cur_mode == MD_SAFE || cur_mode == MD_DRUN || cur_mode == MD_RESET));

  p_safe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|safe_evt) && cur_mode == MD_SAFE && !clk_stopped) |=> (cur_mode == MD_SAFE && !in_trans));

  p_safe_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|safe_evt) && !ill_flag) |=> !ill_flag);

  p_test_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MD_TEST) |-> (mvreg_en && pd_en[1:0] == 2'b11));

  p_pads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pad_hiz |-> (cur_mode == MD_SAFE && !pad_drv_en));

  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stopped |=> (clk_stopped && $stable(ill_flag) && $stable(in_trans)));

  p_reset_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MD_RESET) |-> in_trans);
endmodule

bind opmode_ctrl opmode_ctrl_chk #(.NPD(NPD), .NSAFE(NSAFE)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .safe_evt    (safe_evt),
  .seq_done    (seq_done),
  .cur_mode    (cur_mode),
  .in_trans    (in_trans),
  .ill_flag    (ill_flag),
  .mvreg_en    (mvreg_en),
  .pd_en       (pd_en),
  .pad_hiz     (pad_hiz),
  .pad_drv_en  (pad_drv_en),
  .clk_stopped (clk_stopped)
);

// File: tb/sim_opmode_ctrl.sv
module sim_opmode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NPD   = 4;
  localparam int NSAFE = 2;
  localparam int CFG_W = 6 + NPD;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 wr_en;
  logic [3:0]           wr_mode;
  logic [NSAFE-1:0]     safe_evt;
  logic                 seq_done;
  logic [8*CFG_W-1:0]   cfg_all;
  logic [3:0]           cur_mode, sysclk_sel;
  logic                 in_trans, ill_flag, mvreg_en, pad_hiz, pad_drv_en, clk_stopped;
  logic [NPD-1:0]       pd_en;

  logic [3:0] m_cur, m_tgt;
  logic       m_tr, m_ill;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opmode_ctrl #(.NPD(NPD), .NSAFE(NSAFE)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode), .safe_evt(safe_evt),
    .seq_done(seq_done), .cfg_all(cfg_all), .cur_mode(cur_mode), .in_trans(in_trans),
    .ill_flag(ill_flag), .sysclk_sel(sysclk_sel), .mvreg_en(mvreg_en), .pd_en(pd_en),
    .pad_hiz(pad_hiz), .pad_drv_en(pad_drv_en), .clk_stopped(clk_stopped)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CFG_W-1:0] word_of(input logic [3:0] m);
    return cfg_all[m*CFG_W +: CFG_W];
  endfunction

  function automatic logic legal_req(input logic [3:0] cur, input logic [3:0] req);
    if (req > 4'd7 || req == cur) return 1'b0;
    if (cur == 4'd2 && !(req == 4'd3 || req == 4'd0)) return 1'b0;
    if (req == 4'd1 && cur != 4'd3) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_step(input logic we, input logic [3:0] wm, input logic sa, input logic dn);
    logic [CFG_W-1:0] tw;
    tw = word_of(4'd1);
    if (m_cur == 4'd1 && tw[3:0] == 4'hF) return;
    if (sa) begin
      if (m_cur == 4'd2) begin m_tgt = 4'd2; m_tr = 1'b0; end
      else if (m_tr && m_tgt == 4'd2 && dn) begin m_cur = 4'd2; m_tr = 1'b0; end
      else begin m_tgt = 4'd2; m_tr = 1'b1; end
    end else if (we && m_tr && m_tgt == 4'd2 && wm == m_cur) begin
      m_tgt = m_cur;
    end else if (m_tr) begin
      if (we) m_ill = 1'b1;
      if (dn) begin
        if (m_tgt == 4'd0) begin m_cur = 4'd0; m_tgt = 4'd3; end
        else begin m_cur = m_tgt; m_tr = 1'b0; end
      end
    end else if (we) begin
      if (legal_req(m_cur, wm)) begin m_tgt = wm; m_tr = 1'b1; end
      else m_ill = 1'b1;
    end
  endtask

  task automatic cmp_all();
    logic [CFG_W-1:0] w;
    logic [NPD-1:0]   e_pd;
    w = word_of(m_cur);
    e_pd = w[5 +: NPD] | ((m_cur == 4'd1) ? NPD'(3) : '0);
    chk("R2 mode", {28'd0, cur_mode}, {28'd0, m_cur});
    chk("R2 trans", {31'd0, in_trans}, {31'd0, m_tr});
    chk("R4 flag", {31'd0, ill_flag}, {31'd0, m_ill});
    chk("R3 clksel", {28'd0, sysclk_sel}, {28'd0, w[3:0]});
    chk("R9 reg", {31'd0, mvreg_en}, {31'd0, w[4] | (m_cur == 4'd1)});
    chk("R9 pd", 32'(pd_en), 32'(e_pd));
    chk("R10 hiz", {31'd0, pad_hiz}, {31'd0, (m_cur == 4'd2) & w[5+NPD]});
    chk("R10 drv", {31'd0, pad_drv_en}, {31'd0, !((m_cur == 4'd2) & w[5+NPD])});
    chk("R11 stop", {31'd0, clk_stopped}, {31'd0, (m_cur == 4'd1) && w[3:0] == 4'hF});
  endtask

  task automatic cyc(input logic we, input logic [3:0] wm, input logic [NSAFE-1:0] sa, input logic dn);
    @(negedge clk);
    wr_en = we; wr_mode = wm; safe_evt = sa; seq_done = dn;
    @(posedge clk);
    model_step(we, wm, |sa, dn);
    #1;
    cmp_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; wr_mode = 4'd0; safe_evt = '0; seq_done = 1'b0;
    @(negedge clk);
    m_cur = 4'd0; m_tgt = 4'd3; m_tr = 1'b1; m_ill = 1'b0;
    chk("R1 mode", {28'd0, cur_mode}, 32'd0);
    chk("R1 trans", {31'd0, in_trans}, 32'd1);
    chk("R1 flag", {31'd0, ill_flag}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic set_word(input int m, input logic [CFG_W-1:0] w);
    cfg_all[m*CFG_W +: CFG_W] = w;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    cfg_all = '0;
    for (int m = 0; m < 8; m++) set_word(m, CFG_W'(m * 37 + 5) & ~CFG_W'(15) | CFG_W'(m));
    rst_n = 1'b0;
    do_reset();

    // R1: first done lands in DRUN
    cyc(0, 0, 0, 1);
    chk("R1 drun", {28'd0, cur_mode}, 32'd3);

    // R5: TEST from DRUN, then R9 forced enables
    set_word(1, '0);
    set_word(1, CFG_W'(2));
    cyc(1, 4'd1, 0, 0);
    chk("R5 pending", {31'd0, in_trans}, 32'd1);
    chk("R3 old cfg held", {28'd0, sysclk_sel}, 32'(word_of(4'd3) & 4'hF));
    cyc(0, 0, 0, 1);
    chk("R5 in test", {28'd0, cur_mode}, 32'd1);
    chk("R9 reg forced", {31'd0, mvreg_en}, 32'd1);
    chk("R9 pd forced", 32'(pd_en), 32'd3);
    cyc(1, 4'd3, 0, 0);
    cyc(0, 0, 0, 1);
    cyc(1, 4'd4, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R2 run0", {28'd0, cur_mode}, 32'd4);
    cyc(1, 4'd1, 0, 0);
    chk("R5 illegal from run0", {31'd0, ill_flag}, 32'd1);
    chk("R5 stays", {28'd0, cur_mode}, 32'd4);

    // R4: undefined code, busy write
    do_reset();
    cyc(1, 4'd3, 0, 0);
    chk("R4 busy write", {31'd0, ill_flag}, 32'd1);
    do_reset();
    cyc(0, 0, 0, 1);
    cyc(1, 4'd9, 0, 0);
    chk("R4 undefined", {31'd0, ill_flag}, 32'd1);
    chk("R4 no move", {31'd0, in_trans}, 32'd0);

    // R7: redirect back to parent
    do_reset();
    cyc(0, 0, 0, 1);
    cyc(1, 4'd2, 0, 0);
    cyc(1, 4'd3, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R7 parent", {28'd0, cur_mode}, 32'd3);
    chk("R7 no flag", {31'd0, ill_flag}, 32'd0);

    // R6: SAFE exits
    cyc(1, 4'd2, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R6 in safe", {28'd0, cur_mode}, 32'd2);
    cyc(1, 4'd5, 0, 0);
    chk("R6 run1 refused", {31'd0, ill_flag}, 32'd1);
    cyc(1, 4'd3, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R6 drun", {28'd0, cur_mode}, 32'd3);

    // R8 + R10: fault event with pad disable
    do_reset();
    set_word(2, CFG_W'(1) << (5 + NPD));
    cyc(0, 0, 0, 1);
    cyc(1, 4'd4, 0, 0);
    cyc(1, 4'd5, 2'b10, 1);
    chk("R8 preempt", {28'd0, cur_mode}, 32'd3);
    cyc(1, 4'd0, 2'b01, 1);
    chk("R8 safe", {28'd0, cur_mode}, 32'd2);
    chk("R10 hiz", {31'd0, pad_hiz}, 32'd1);
    chk("R10 drv off", {31'd0, pad_drv_en}, 32'd0);
    cyc(1, 4'd3, 2'b11, 1);
    chk("R8 locked", {28'd0, cur_mode}, 32'd2);
    chk("R8 no flag", {31'd0, ill_flag}, 32'd0);

    // R12: software reset
    cyc(1, 4'd3, 0, 0);
    cyc(0, 0, 0, 1);
    cyc(1, 4'd0, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R12 reset", {28'd0, cur_mode}, 32'd0);
    chk("R12 pending", {31'd0, in_trans}, 32'd1);
    cyc(0, 0, 0, 1);
    chk("R12 drun", {28'd0, cur_mode}, 32'd3);

    // R11: stopped clock
    set_word(1, CFG_W'(4'hF));
    cyc(1, 4'd1, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R11 stopped", {31'd0, clk_stopped}, 32'd1);
    cyc(1, 4'd3, 2'b01, 1);
    cyc(1, 4'd9, 0, 1);
    chk("R11 frozen", {28'd0, cur_mode}, 32'd1);
    chk("R11 no flag", {31'd0, ill_flag}, 32'd0);

    // random mix
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      if (i % 700 == 0) begin
        for (int m = 0; m < 8; m++) begin
          logic [CFG_W-1:0] w;
          w = CFG_W'($urandom);
          if (m == 1 && w[3:0] == 4'hF) w[3:0] = 4'h0;
          set_word(m, w);
        end
      end
      if ($urandom_range(0, 499) == 0) do_reset();
      else cyc($urandom_range(0, 9) < 3, 4'($urandom_range(0, 9)),
               ($urandom_range(0, 19) == 0) ? NSAFE'($urandom_range(1, 3)) : '0,
               $urandom_range(0, 9) < 3);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule